// File: doc/BRIEF.md
# Dual-Master Shared-Bus Access Arbiter

This block sits between two bus masters, a main CPU and a 16-bit coprocessor, and two shared targets: a fast single-cycle RAM port and a slower peripheral/flash port. The block runs on the coprocessor clock, which is twice the CPU bus rate. A phase output splits every CPU bus cycle into two half-slots. The CPU presents at most one access per CPU cycle, in the first half-slot. The coprocessor may present one access in every half-slot.

Each access is routed by address to the RAM port or to the slow port. The CPU always has priority. Its access goes to the target in the half-slot in which it is presented. When the coprocessor contends for the same resource, or asks for the slow port in a half-slot where that port is not available, it is stalled combinationally and must hold its access until it is granted. The result is that the coprocessor gets up to two RAM accesses per CPU cycle but at most one slow-port access per CPU cycle. Read data comes back on a per-master valid/data pair.

Top module: `dual_master_bus_arb`

## Requirements
- R1: After reset `phase` is 0. It then alternates on every clock, so that 0 marks the first half-slot of a CPU cycle and 1 marks the second.
- R2: A CPU request is granted (`cpu_gnt`=1) whenever `cpu_req` is 1 while `phase`=0. The access is forwarded to its target in that same clock, so the CPU is never stalled or delayed.
- R3: An address below `RAM_LIMIT` (default 0x8000) selects the RAM port. Any other address selects the slow port. By default 0x7FFF goes to RAM and 0x8000 goes to the slow port.
- R4: When the CPU and the coprocessor address the same resource in the same half-slot, the CPU is served. In that clock `cop_stall`=1 and `cop_gnt`=0.
- R5: A coprocessor RAM request in the second half-slot is always granted. When the CPU does not use the RAM, a stream of coprocessor RAM accesses completes one per clock, which is two per CPU cycle. When the CPU takes the RAM on every CPU cycle, the stream completes one per CPU cycle.
- R6: The slow port carries at most one access per CPU cycle. A coprocessor slow-port request is granted only when `phase`=0 and the CPU is not using the slow port in that half-slot.
- R7: A stalled coprocessor request, held stable by the master, is kept pending and not dropped. It completes in the first half-slot in which its resource is free, and it then returns the correct data.
- R8: A granted read raises the master's `*_rvalid` for exactly one clock, the clock after the grant. The data is the word read from the port that was accessed. A granted write produces no valid pulse.
- R9: A CPU request presented while `phase`=1 is ignored. It gets no grant, touches neither port and produces no read valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-slot clock (twice the CPU bus rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | output | 1 | 0 = first half-slot, 1 = second half-slot |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write enable |
| cpu_addr | input | AW | CPU address |
| cpu_wdata | input | DW | CPU write data |
| cpu_gnt | output | 1 | CPU access accepted this clock |
| cpu_rvalid | output | 1 | CPU read data valid |
| cpu_rdata | output | DW | CPU read data |
| cop_req | input | 1 | Coprocessor access request |
| cop_we | input | 1 | Coprocessor write enable |
| cop_addr | input | AW | Coprocessor address |
| cop_wdata | input | DW | Coprocessor write data |
| cop_gnt | output | 1 | Coprocessor access accepted this clock |
| cop_stall | output | 1 | Coprocessor request lost this half-slot; hold it |
| cop_rvalid | output | 1 | Coprocessor read data valid |
| cop_rdata | output | DW | Coprocessor read data |
| ram_en | output | 1 | RAM port access strobe |
| ram_we | output | 1 | RAM port write enable |
| ram_addr | output | AW | RAM port address |
| ram_wdata | output | DW | RAM port write data |
| ram_rdata | input | DW | RAM port read data, one clock after the strobe |
| slow_en | output | 1 | Slow port access strobe |
| slow_we | output | 1 | Slow port write enable |
| slow_addr | output | AW | Slow port address |
| slow_wdata | output | DW | Slow port write data |
| slow_rdata | input | DW | Slow port read data, one clock after the strobe |

## Verification
The assertions check on every clock that the phase alternates, that a granted CPU access appears on its target port unchanged, and that a port never has two owners. They also check that a same-resource conflict stalls the coprocessor, that the slow port is never strobed in two consecutive clocks, and that a write never raises a read valid. The bench scenarios are needed to show the throughput figures: two RAM completions per idle CPU cycle, one per CPU cycle under full CPU load, and one slow-port completion per CPU cycle. They also show the exact stall counts in the two conflict cases, the address boundary, and that stalled accesses under random contention still return the data a golden memory predicts.

// File: rtl/dmba_pkg.sv
package dmba_pkg;
   typedef enum logic {
      TGT_RAM  = 1'b0,
      TGT_SLOW = 1'b1
   } tgt_e;

   localparam int NPORT = 2;
endpackage

// File: rtl/dmba_decode.sv
module dmba_decode
   import dmba_pkg::*;
#(
   parameter int          AW          = 16,
   parameter int unsigned RAM_LIMIT   = 32'h8000,
   parameter bit          MASK_DECODE = 1'b1
) (
   input  logic [AW-1:0] addr,
   output tgt_e          tgt
);
   localparam logic [AW-1:0] LIM      = AW'(RAM_LIMIT);
   localparam logic [AW-1:0] LOW_MASK = LIM - 1'b1;

   if (RAM_LIMIT < 1 || longint'(RAM_LIMIT) >= (longint'(1) << AW)) begin : g_bad_limit
      $error("dmba_decode: RAM_LIMIT must lie in 1 .. 2**AW-1");
   end
   if (AW < 2 || AW > 31) begin : g_bad_aw
      $error("dmba_decode: AW out of range");
   end

   if (MASK_DECODE) begin : g_mask
      if ((RAM_LIMIT & (RAM_LIMIT - 1)) != 0) begin : g_not_pow2
         $error("dmba_decode: mask decode needs a power-of-two RAM_LIMIT");
      end
      always_comb begin
         tgt = ((addr & ~LOW_MASK) != '0) ? TGT_SLOW : TGT_RAM;
      end
   end else begin : g_compare
      always_comb begin
         tgt = (addr < LIM) ? TGT_RAM : TGT_SLOW;
      end
   end
endmodule

// File: rtl/dmba_slot_ctrl.sv
module dmba_slot_ctrl
   import dmba_pkg::*;
#(
   parameter int COP_RAM_SLOTS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_req,
   input  tgt_e cpu_tgt,
   input  logic cop_req,
   input  tgt_e cop_tgt,
   output logic phase,
   output logic cpu_gnt,
   output logic cop_gnt,
   output logic cop_stall
);
   logic phase_q;
   logic ram_busy;
   logic slow_busy;

   if (COP_RAM_SLOTS != 1 && COP_RAM_SLOTS != 2) begin : g_bad_slots
      $error("dmba_slot_ctrl: COP_RAM_SLOTS must be 1 or 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= 1'b0;
      else        phase_q <= ~phase_q;
   end

   assign phase   = phase_q;
   assign cpu_gnt = cpu_req & ~phase_q;

   if (COP_RAM_SLOTS == 2) begin : g_two_slots
      always_comb ram_busy = cpu_gnt && (cpu_tgt == TGT_RAM);
   end else begin : g_one_slot
      always_comb ram_busy = ~phase_q;
   end

   always_comb begin
      slow_busy = phase_q | (cpu_gnt && (cpu_tgt == TGT_SLOW));
      cop_stall = cop_req && ((cop_tgt == TGT_RAM) ? ram_busy : slow_busy);
      cop_gnt   = cop_req && !cop_stall;
   end

   // R4: the CPU wins any same-resource contest
   a_r4_cpu_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !phase_q && cop_req && (cop_tgt == cpu_tgt)) |-> (cop_stall && !cop_gnt));

   // R6: coprocessor never reaches the slow port in the second half-slot
   a_r6_slow_first_half: assert property (@(posedge clk) disable iff (!rst_n)
      (cop_req && phase_q && (cop_tgt == TGT_SLOW)) |-> cop_stall);
endmodule

// File: rtl/dmba_port_mux.sv
module dmba_port_mux
   import dmba_pkg::*;
#(
   parameter int   AW     = 16,
   parameter int   DW     = 16,
   parameter tgt_e MY_TGT = TGT_RAM
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_gnt,
   input  tgt_e          cpu_tgt,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   input  logic          cop_gnt,
   input  tgt_e          cop_tgt,
   input  logic          cop_we,
   input  logic [AW-1:0] cop_addr,
   input  logic [DW-1:0] cop_wdata,
   output logic          en,
   output logic          we,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] wdata
);
   logic sel_cpu;
   logic sel_cop;

   always_comb begin
      sel_cpu = cpu_gnt && (cpu_tgt == MY_TGT);
      sel_cop = cop_gnt && (cop_tgt == MY_TGT);
      en      = sel_cpu | sel_cop;
      we      = sel_cpu ? cpu_we    : (sel_cop & cop_we);
      addr    = sel_cpu ? cpu_addr  : cop_addr;
      wdata   = sel_cpu ? cpu_wdata : cop_wdata;
   end

   // R4: one owner per port per half-slot
   a_r4_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_cpu && sel_cop));
endmodule

// File: rtl/dmba_rsp_route.sv
module dmba_rsp_route
   import dmba_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_gnt,
   input  logic          cpu_we,
   input  tgt_e          cpu_tgt,
   input  logic          cop_gnt,
   input  logic          cop_we,
   input  tgt_e          cop_tgt,
   input  logic [DW-1:0] ram_rdata,
   input  logic [DW-1:0] slow_rdata,
   output logic          cpu_rvalid,
   output logic [DW-1:0] cpu_rdata,
   output logic          cop_rvalid,
   output logic [DW-1:0] cop_rdata
);
   logic cpu_pend_q;
   logic cop_pend_q;
   tgt_e cpu_src_q;
   tgt_e cop_src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_pend_q <= 1'b0;
         cop_pend_q <= 1'b0;
         cpu_src_q  <= TGT_RAM;
         cop_src_q  <= TGT_RAM;
      end else begin
         cpu_pend_q <= cpu_gnt & ~cpu_we;
         cop_pend_q <= cop_gnt & ~cop_we;
         if (cpu_gnt) cpu_src_q <= cpu_tgt;
         if (cop_gnt) cop_src_q <= cop_tgt;
      end
   end

   assign cpu_rvalid = cpu_pend_q;
   assign cop_rvalid = cop_pend_q;
   assign cpu_rdata  = (cpu_src_q == TGT_SLOW) ? slow_rdata : ram_rdata;
   assign cop_rdata  = (cop_src_q == TGT_SLOW) ? slow_rdata : ram_rdata;

   // R8: writes never echo a valid pulse
   a_r8_cpu_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_gnt && cpu_we) |=> !cpu_rvalid);
   a_r8_cop_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (cop_gnt && cop_we) |=> !cop_rvalid);
endmodule

// File: rtl/dual_master_bus_arb.sv
module dual_master_bus_arb
   import dmba_pkg::*;
#(
   parameter int          AW            = 16,
   parameter int          DW            = 16,
   parameter int unsigned RAM_LIMIT     = 32'h8000,
   parameter bit          MASK_DECODE   = 1'b1,
   parameter int          COP_RAM_SLOTS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          phase,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_gnt,
   output logic          cpu_rvalid,
   output logic [DW-1:0] cpu_rdata,
   input  logic          cop_req,
   input  logic          cop_we,
   input  logic [AW-1:0] cop_addr,
   input  logic [DW-1:0] cop_wdata,
   output logic          cop_gnt,
   output logic          cop_stall,
   output logic          cop_rvalid,
   output logic [DW-1:0] cop_rdata,
   output logic          ram_en,
   output logic          ram_we,
   output logic [AW-1:0] ram_addr,
   output logic [DW-1:0] ram_wdata,
   input  logic [DW-1:0] ram_rdata,
   output logic          slow_en,
   output logic          slow_we,
   output logic [AW-1:0] slow_addr,
   output logic [DW-1:0] slow_wdata,
   input  logic [DW-1:0] slow_rdata
);
   if (DW < 1) begin : g_bad_dw
      $error("dual_master_bus_arb: DW must be positive");
   end

   tgt_e cpu_tgt;
   tgt_e cop_tgt;

   dmba_decode #(.AW(AW), .RAM_LIMIT(RAM_LIMIT), .MASK_DECODE(MASK_DECODE)) u_dec_cpu (
      .addr (cpu_addr),
      .tgt  (cpu_tgt)
   );

   dmba_decode #(.AW(AW), .RAM_LIMIT(RAM_LIMIT), .MASK_DECODE(MASK_DECODE)) u_dec_cop (
      .addr (cop_addr),
      .tgt  (cop_tgt)
   );

   dmba_slot_ctrl #(.COP_RAM_SLOTS(COP_RAM_SLOTS)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .cpu_tgt   (cpu_tgt),
      .cop_req   (cop_req),
      .cop_tgt   (cop_tgt),
      .phase     (phase),
      .cpu_gnt   (cpu_gnt),
      .cop_gnt   (cop_gnt),
      .cop_stall (cop_stall)
   );

   logic          port_en    [NPORT];
   logic          port_we    [NPORT];
   logic [AW-1:0] port_addr  [NPORT];
   logic [DW-1:0] port_wdata [NPORT];

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      dmba_port_mux #(.AW(AW), .DW(DW), .MY_TGT(tgt_e'(p))) u_mux (
         .clk       (clk),
         .rst_n     (rst_n),
         .cpu_gnt   (cpu_gnt),
         .cpu_tgt   (cpu_tgt),
         .cpu_we    (cpu_we),
         .cpu_addr  (cpu_addr),
         .cpu_wdata (cpu_wdata),
         .cop_gnt   (cop_gnt),
         .cop_tgt   (cop_tgt),
         .cop_we    (cop_we),
         .cop_addr  (cop_addr),
         .cop_wdata (cop_wdata),
         .en        (port_en[p]),
         .we        (port_we[p]),
         .addr      (port_addr[p]),
         .wdata     (port_wdata[p])
      );
   end

   assign ram_en     = port_en[TGT_RAM];
   assign ram_we     = port_we[TGT_RAM];
   assign ram_addr   = port_addr[TGT_RAM];
   assign ram_wdata  = port_wdata[TGT_RAM];
   assign slow_en    = port_en[TGT_SLOW];
   assign slow_we    = port_we[TGT_SLOW];
   assign slow_addr  = port_addr[TGT_SLOW];
   assign slow_wdata = port_wdata[TGT_SLOW];

   dmba_rsp_route #(.DW(DW)) u_rsp (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_gnt    (cpu_gnt),
      .cpu_we     (cpu_we),
      .cpu_tgt    (cpu_tgt),
      .cop_gnt    (cop_gnt),
      .cop_we     (cop_we),
      .cop_tgt    (cop_tgt),
      .ram_rdata  (ram_rdata),
      .slow_rdata (slow_rdata),
      .cpu_rvalid (cpu_rvalid),
      .cpu_rdata  (cpu_rdata),
      .cop_rvalid (cop_rvalid),
      .cop_rdata  (cop_rdata)
   );

   // R1: half-slot phase alternates
   a_r1_phase_alternates: assert property (@(posedge clk) disable iff (!rst_n)
      !phase |=> phase);

   // R2: a granted CPU access reaches its port unaltered in the same clock
   a_r2_cpu_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_gnt |-> ((cpu_tgt == TGT_RAM)
                   ? (ram_en && ram_addr == cpu_addr && ram_we == cpu_we)
                   : (slow_en && slow_addr == cpu_addr && slow_we == cpu_we)));

   // R5: second half-slot RAM access by the coprocessor is never refused
   if (COP_RAM_SLOTS == 2) begin : g_r5_chk
      a_r5_second_half_free: assert property (@(posedge clk) disable iff (!rst_n)
         (phase && cop_req && cop_tgt == TGT_RAM) |-> (ram_en && !cop_stall));
   end

   // R6: slow port strobed at most once per CPU cycle
   a_r6_slow_once: assert property (@(posedge clk) disable iff (!rst_n)
      slow_en |=> !slow_en);

   // R7: a RAM stall in the first half-slot clears in the second
   a_r7_ram_retry: assert property (@(posedge clk) disable iff (!rst_n)
      (cop_stall && cop_tgt == TGT_RAM && !phase) |=> !(cop_stall && cop_tgt == TGT_RAM));
endmodule

// File: tb/tb_dual_master_bus_arb.sv
module tb_dual_master_bus_arb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          phase;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_gnt, cpu_rvalid;
   logic [DW-1:0] cpu_rdata;
   logic          cop_req = 1'b0, cop_we = 1'b0;
   logic [AW-1:0] cop_addr = '0;
   logic [DW-1:0] cop_wdata = '0;
   logic          cop_gnt, cop_stall, cop_rvalid;
   logic [DW-1:0] cop_rdata;
   logic          ram_en, ram_we, slow_en, slow_we;
   logic [AW-1:0] ram_addr, slow_addr;
   logic [DW-1:0] ram_wdata, slow_wdata;
   logic [DW-1:0] ram_rdata = '0, slow_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_master_bus_arb dut (
      .clk(clk), .rst_n(rst_n), .phase(phase),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_gnt(cpu_gnt), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
      .cop_req(cop_req), .cop_we(cop_we), .cop_addr(cop_addr), .cop_wdata(cop_wdata),
      .cop_gnt(cop_gnt), .cop_stall(cop_stall), .cop_rvalid(cop_rvalid), .cop_rdata(cop_rdata),
      .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata),
      .slow_en(slow_en), .slow_we(slow_we), .slow_addr(slow_addr), .slow_wdata(slow_wdata),
      .slow_rdata(slow_rdata)
   );

   // single-cycle target models
   logic [DW-1:0] ram_mem  [64];
   logic [DW-1:0] slow_mem [64];
   logic [DW-1:0] sh_ram   [64];
   logic [DW-1:0] sh_slow  [64];

   initial begin
      for (int i = 0; i < 64; i++) begin
         ram_mem[i]  = 16'h1000 + 16'(i);
         slow_mem[i] = 16'h2000 + 16'(i);
         sh_ram[i]   = 16'h1000 + 16'(i);
         sh_slow[i]  = 16'h2000 + 16'(i);
      end
   end

   always @(posedge clk) begin
      if (ram_en) begin
         if (ram_we) ram_mem[ram_addr[5:0]] <= ram_wdata;
         else        ram_rdata <= ram_mem[ram_addr[5:0]];
      end
      if (slow_en) begin
         if (slow_we) slow_mem[slow_addr[5:0]] <= slow_wdata;
         else         slow_rdata <= slow_mem[slow_addr[5:0]];
      end
   end

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit is_ram(input logic [AW-1:0] a);
      return a < 16'h8000;
   endfunction

   logic [DW-1:0] cpu_q [$];
   logic [DW-1:0] cop_q [$];

   // monitor: pops expected read data as valid pulses arrive
   always @(negedge clk) begin
      if (rst_n) begin
         if (cpu_rvalid) begin
            if (cpu_q.size() == 0) chk("R8 unexpected cpu_rvalid", 1, 0);
            else chk("R8 cpu read data", cpu_rdata, cpu_q.pop_front());
         end
         if (cop_rvalid) begin
            if (cop_q.size() == 0) chk("R8 unexpected cop_rvalid", 1, 0);
            else chk("R7 cop read data", cop_rdata, cop_q.pop_front());
         end
      end
   end

   // driver tasks: entered and left just after a rising edge
   task automatic cpu_acc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      if (phase) begin
         cpu_req = 1'b0;
         @(posedge clk); #1;
      end
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      chk("R2 cpu granted without delay", cpu_gnt, 1);
      chk("R3 cpu routed by address", is_ram(a) ? ram_en : slow_en, 1);
      if (is_ram(a)) begin
         if (we) sh_ram[a[5:0]] = d; else cpu_q.push_back(sh_ram[a[5:0]]);
      end else begin
         if (we) sh_slow[a[5:0]] = d; else cpu_q.push_back(sh_slow[a[5:0]]);
      end
      @(posedge clk); #1;
      cpu_req = 1'b0;
   endtask

   task automatic cop_acc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output int stalls, output int gcyc);
      cop_req = 1'b1; cop_we = we; cop_addr = a; cop_wdata = d;
      stalls = 0;
      while (1) begin
         @(negedge clk);
         if (!cop_stall) break;
         stalls++;
         @(posedge clk); #1;
      end
      gcyc = cyc;
      chk("R7 cop granted once free", cop_gnt, 1);
      if (is_ram(a)) begin
         if (we) sh_ram[a[5:0]] = d; else cop_q.push_back(sh_ram[a[5:0]]);
      end else begin
         if (we) sh_slow[a[5:0]] = d; else cop_q.push_back(sh_slow[a[5:0]]);
      end
      @(posedge clk); #1;
   endtask

   task automatic align_p0();
      while (phase) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int st, g, g0, s0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset phase", phase, 0);
      chk("R8 reset cpu_rvalid", cpu_rvalid, 0);
      chk("R8 reset cop_rvalid", cop_rvalid, 0);
      chk("R4 reset cop_stall", cop_stall, 0);
      chk("R2 reset ram_en", ram_en, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 phase after first edge", phase, 1);
      @(posedge clk); #1;
      chk("R1 phase after second edge", phase, 0);

      // R3 boundary
      cpu_acc(1'b1, 16'h7FFF, 16'hA5A5);
      cpu_acc(1'b1, 16'h8000, 16'h5A5A);
      cpu_acc(1'b0, 16'h7FFF, 16'h0);
      cpu_acc(1'b0, 16'h8000, 16'h0);

      // R9: request in the second half-slot is ignored
      align_p0();
      @(posedge clk); #1;
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h0005; cpu_wdata = 16'hDEAD;
      @(negedge clk);
      chk("R9 no grant in second half", cpu_gnt, 0);
      chk("R9 no ram strobe", ram_en, 0);
      chk("R9 no slow strobe", slow_en, 0);
      @(posedge clk); #1;
      cpu_req = 1'b0;
      @(negedge clk);
      chk("R9 no read valid", cpu_rvalid, 0);
      @(posedge clk); #1;
      cpu_acc(1'b0, 16'h0005, 16'h0);

      // R4: RAM conflict costs exactly one half-slot
      align_p0();
      fork
         cpu_acc(1'b1, 16'h0009, 16'h1234);
         begin cop_acc(1'b0, 16'h0009, 16'h0, st, g); cop_req = 1'b0; end
      join
      chk("R4 cop stalls one half-slot", st, 1);

      // R6: slow conflict waits for the next first half-slot
      align_p0();
      fork
         cpu_acc(1'b1, 16'h8003, 16'h4321);
         begin cop_acc(1'b0, 16'h8003, 16'h0, st, g); cop_req = 1'b0; end
      join
      chk("R6 cop slow stall count", st, 2);

      // R5: idle CPU, eight RAM reads in eight clocks
      align_p0();
      cop_acc(1'b0, 16'h0000, 16'h0, s0, g0);
      g0 = g0 - s0;
      for (int i = 1; i < 8; i++) cop_acc(1'b0, 16'(i), 16'h0, st, g);
      cop_req = 1'b0;
      chk("R5 two RAM completions per CPU cycle", g - g0 + 1, 8);

      // R5: CPU on RAM every cycle, one coprocessor RAM access per cycle
      align_p0();
      fork
         for (int i = 0; i < 8; i++) cpu_acc(1'b1, 16'(8 + i), 16'hC000 + 16'(i));
         begin
            cop_acc(1'b0, 16'h0000, 16'h0, s0, g0);
            g0 = g0 - s0;
            for (int i = 1; i < 8; i++) cop_acc(1'b0, 16'(i), 16'h0, st, g);
            cop_req = 1'b0;
         end
      join
      chk("R5 one RAM completion per cycle under CPU load", g - g0 + 1, 16);

      // R6: four slow reads take seven half-slots from a first half-slot
      align_p0();
      cop_acc(1'b0, 16'h8010, 16'h0, s0, g0);
      g0 = g0 - s0;
      for (int i = 1; i < 4; i++) cop_acc(1'b0, 16'h8010 + 16'(i), 16'h0, st, g);
      cop_req = 1'b0;
      chk("R6 one slow completion per CPU cycle", g - g0 + 1, 7);

      // random contention
      fork
         for (int i = 0; i < 60; i++) begin
            logic [AW-1:0] a;
            a = ($urandom % 2) ? {1'b1, 9'($urandom), 6'($urandom % 8)}
                               : {1'b0, 9'($urandom), 6'($urandom % 8)};
            cpu_acc(1'($urandom), a, 16'($urandom));
            repeat ($urandom % 3) begin @(posedge clk); #1; end
         end
         begin
            for (int i = 0; i < 120; i++) begin
               logic [AW-1:0] a;
               a = ($urandom % 3 == 0) ? {1'b1, 9'($urandom), 6'($urandom % 8)}
                                       : {1'b0, 9'($urandom), 6'($urandom % 8)};
               cop_acc(1'($urandom), a, 16'($urandom), st, g);
               if ($urandom % 4 == 0) begin
                  cop_req = 1'b0;
                  @(posedge clk); #1;
               end
            end
            cop_req = 1'b0;
         end
      join

      repeat (4) @(posedge clk);
      #1;
      chk("R7 no cpu read left pending", cpu_q.size(), 0);
      chk("R7 no cop read dropped", cop_q.size(), 0);
      finish_run();
   end
endmodule